// File: doc/BRIEF.md
# Synchronized Dual NCO Waveform Generator

This block drives the transmitter and the receive mixer of a coherent HF radar from one clock. It has two 48-bit phase accumulators. Both run from a single tuning word and are cleared together by one go command. The first accumulator gives the transmit phase. The second gives a local-oscillator phase pair, in-phase and quadrature, a quarter turn apart. Each phase is turned into a 14-bit signed sine amplitude by a quarter-wave lookup. The lookup is pipelined over two clocks.

Two waveforms are available. Ramp mode steps the tuning word by a signed increment once every tick period, for a programmed number of steps, and then returns to the base frequency. This gives a repeating linear sweep. Coded mode holds the tuning word constant and adds a half turn to a phase whenever the pseudo-random chip for that path is 1. The chip sequence comes from a 10-bit maximal-length shift register (polynomial x^10 + x^7 + 1) that advances once per tick period. The local oscillator sees the transmit chips delayed by a programmable number of chips, which selects the range cell being demodulated.

Settings are written through a small write-only register port into a holding set. The running waveform takes the holding set only on a go command or at the end of the current sweep or code period, so the output never jumps mid-sweep.

Top module: `dual_nco_gen`

## Requirements
- R1: A write to address 6 (go) clears both accumulators on that clock edge and loads the held settings. In the cycle after that edge, every bit of tx_phase and lo_i_phase other than bit 47 is zero.
- R2: While running, each accumulator adds the current 48-bit tuning word on every clock, wrapping modulo 2^48. In ramp mode with a zero increment, tx_phase equals N times the base word (address 0) N clocks after go.
- R3: The transmit and LO accumulators hold the same value at all times, so tx_phase and lo_i_phase differ at most in bit 47.
- R4: lo_q_phase always equals lo_i_phase + 2^46 modulo 2^48.
- R5: In ramp mode (address 3 bit 0 = 0), the tuning word starts at the base word and is held for T clocks, where T is the tick period at address 5 and 0 counts as 1. It then rises by the signed step at address 1. After L values, where L is the length at address 2 and 0 counts as 1, it returns to the base word.
- R6: In coded mode (address 3 bit 0 = 1), the tuning word is the base word and the increment is ignored. A phase gets 2^47 added while its chip is 1. The transmit chip is bit 9 of a Fibonacci shift register that loads the seed on go, takes the feedback bit9 XOR bit6 into bit 0, and shifts once per tick period.
- R7: In coded mode the LO chip equals the transmit chip from D chips earlier, where D is at address 4 (0 to 1022). For the first D chips after go, the LO chip is 0.
- R8: Writes to addresses 0 to 5 do not change the running waveform until the next boundary. A boundary is the last step of a sweep in ramp mode, or the 1023rd chip in coded mode.
- R9: Each amplitude output equals round(8191·sin(2π(p+0.5)/1024)), to within 1, where p is the top 10 bits of its phase two clocks earlier. Reset clears the amplitudes to 0, and no amplitude ever reaches -8192.
- R10: Before the first go after reset, tx_phase and lo_i_phase stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 base, 1 step, 2 length, 3 mode, 4 delay, 5 tick, 6 go) |
| cfg_wdata | input | 48 | Register write data |
| tx_phase | output | 48 | Transmit phase including code offset |
| lo_i_phase | output | 48 | LO in-phase phase including code offset |
| lo_q_phase | output | 48 | LO quadrature phase |
| tx_amp | output | 14 | Transmit sine amplitude, signed |
| lo_i_amp | output | 14 | LO in-phase amplitude, signed |
| lo_q_amp | output | 14 | LO quadrature amplitude, signed |

## Verification
The hardest case to reach from the ports is the LO chip at the maximum delay of 1022. It can only be seen after more than a full code period, and only if the delay history survives the period boundary intact. The bench sets the tuning word to zero, so each phase port shows its chip directly as bit 47. It then runs through the 1023-chip boundary with an independently generated sequence. In a separate run, a mode change is queued mid-period, and the bench confirms that it takes effect exactly at that boundary cycle.

// File: rtl/dnco_pkg.sv
package dnco_pkg;

    parameter int PHASE_W = 48;
    parameter int AMP_W   = 14;
    parameter int LUT_AW  = 8;
    parameter int PRN_W   = 10;
    parameter int PRN_TAP = 7;
    parameter int CNT_W   = 16;
    parameter int ADDR_W  = 3;

    localparam int DELAY_W = PRN_W;

    typedef logic [PHASE_W-1:0] phase_t;

    localparam phase_t HALF_TURN    = {1'b1, {(PHASE_W-1){1'b0}}};
    localparam phase_t QUARTER_TURN = {2'b01, {(PHASE_W-2){1'b0}}};

    typedef enum logic {
        WAVE_RAMP  = 1'b0,
        WAVE_CODED = 1'b1
    } wave_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_BASE  = 3'd0,
        REG_STEP  = 3'd1,
        REG_LEN   = 3'd2,
        REG_MODE  = 3'd3,
        REG_DELAY = 3'd4,
        REG_TICK  = 3'd5,
        REG_GO    = 3'd6
    } reg_e;

    typedef struct packed {
        phase_t               base;
        phase_t               step;
        logic [CNT_W-1:0]     len;
        wave_e                mode;
        logic [DELAY_W-1:0]   delay;
        logic [CNT_W-1:0]     tick;
    } wave_cfg_t;

    // One quarter-wave sample, centred half an index into its cell.
    function automatic logic [AMP_W-2:0] quarter_sine(int idx, int aw);
        real ang;
        real v;
        ang = 3.14159265358979 * (real'(idx) + 0.5) / real'(2 * (1 << aw));
        v   = real'((1 << (AMP_W - 1)) - 1) * $sin(ang);
        return (AMP_W-1)'($rtoi(v + 0.5));
    endfunction

endpackage

// File: rtl/dnco_phase_acc.sv
module dnco_phase_acc #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] incr,
    output logic [W-1:0] acc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + incr;
        end
    end

endmodule

// File: rtl/dnco_prn_chips.sv
module dnco_prn_chips #(
    parameter int           W    = 10,
    parameter int           TAP  = 7,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         advance,
    input  logic [W-1:0] delay,
    output logic         tx_chip,
    output logic         lo_chip,
    output logic         last_chip
);

    localparam int DEPTH = (1 << W) - 1;

    logic [W-1:0]     lfsr;
    logic [W-1:0]     lfsr_nxt;
    logic [W-1:0]     chip_idx;
    logic [DEPTH-1:0] hist;

    assign lfsr_nxt  = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[TAP-1]};
    assign tx_chip   = lfsr[W-1];
    assign last_chip = (chip_idx == W'(DEPTH - 1));
    assign lo_chip   = (delay == '0) ? tx_chip : hist[delay - 1'b1];

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            lfsr     <= SEED;
            chip_idx <= '0;
            hist     <= '0;
        end else if (advance) begin
            hist <= {hist[DEPTH-2:0], tx_chip};
            if (last_chip) begin
                chip_idx <= '0;
                lfsr     <= SEED;
            end else begin
                chip_idx <= chip_idx + 1'b1;
                lfsr     <= lfsr_nxt;
            end
        end
    end

endmodule

// File: rtl/dnco_sine_lut.sv
module dnco_sine_lut #(
    parameter int AW    = 8,
    parameter int OUT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW+1:0]           ph,
    output logic signed [OUT_W-1:0] amp
);

    localparam int ENTRIES = 1 << AW;

    logic [OUT_W-2:0] rom [ENTRIES];
    logic [AW-1:0]    addr_q;
    logic             neg_q;
    logic [OUT_W-2:0] mag;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
        localparam logic [OUT_W-2:0] VAL = dnco_pkg::quarter_sine(i, AW);
        assign rom[i] = VAL;
    end

    assign mag = rom[addr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            neg_q  <= 1'b0;
            amp    <= '0;
        end else begin
            addr_q <= ph[AW] ? ~ph[AW-1:0] : ph[AW-1:0];
            neg_q  <= ph[AW+1];
            amp    <= neg_q ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
        end
    end

endmodule

// File: rtl/dual_nco_gen.sv
module dual_nco_gen
    import dnco_pkg::*;
#(
    parameter logic [PRN_W-1:0] PRN_SEED = 10'h001
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [PHASE_W-1:0]      cfg_wdata,
    output logic [PHASE_W-1:0]      tx_phase,
    output logic [PHASE_W-1:0]      lo_i_phase,
    output logic [PHASE_W-1:0]      lo_q_phase,
    output logic signed [AMP_W-1:0] tx_amp,
    output logic signed [AMP_W-1:0] lo_i_amp,
    output logic signed [AMP_W-1:0] lo_q_amp
);

    localparam int LUT_IN_W = LUT_AW + 2;

    wave_cfg_t        shadow_q;
    wave_cfg_t        active_q;
    logic             running;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] step_idx;
    phase_t           ftw_q;

    logic             go;
    logic [CNT_W-1:0] tick_lim;
    logic [CNT_W-1:0] len_lim;
    logic             tick;
    logic             coded;
    logic             boundary;
    logic             tx_chip;
    logic             lo_chip;
    logic             last_chip;
    phase_t           tx_acc;
    phase_t           lo_acc;

    assign go       = cfg_we && (cfg_addr == REG_GO);
    assign tick_lim = (active_q.tick == '0) ? CNT_W'(1) : active_q.tick;
    assign len_lim  = (active_q.len == '0) ? CNT_W'(1) : active_q.len;
    assign tick     = running && (tick_cnt == tick_lim - 1'b1);
    assign coded    = (active_q.mode == WAVE_CODED);
    assign boundary = tick && (coded ? last_chip : (step_idx == len_lim - 1'b1));

    // Holding register set, written from the configuration port.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_BASE:  shadow_q.base  <= cfg_wdata;
                REG_STEP:  shadow_q.step  <= cfg_wdata;
                REG_LEN:   shadow_q.len   <= cfg_wdata[CNT_W-1:0];
                REG_MODE:  shadow_q.mode  <= wave_e'(cfg_wdata[0]);
                REG_DELAY: shadow_q.delay <= cfg_wdata[DELAY_W-1:0];
                REG_TICK:  shadow_q.tick  <= cfg_wdata[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    // Sweep sequencing and boundary-aligned reload of the running set.
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            running  <= 1'b0;
            tick_cnt <= '0;
            step_idx <= '0;
            ftw_q    <= '0;
        end else if (go) begin
            active_q <= shadow_q;
            running  <= 1'b1;
            tick_cnt <= '0;
            step_idx <= '0;
            ftw_q    <= shadow_q.base;
        end else if (running) begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (boundary) begin
                active_q <= shadow_q;
                step_idx <= '0;
                ftw_q    <= shadow_q.base;
            end else if (tick && !coded) begin
                step_idx <= step_idx + 1'b1;
                ftw_q    <= ftw_q + active_q.step;
            end
        end
    end

    dnco_phase_acc #(.W(PHASE_W)) u_tx_acc (
        .clk (clk),
        .rst (rst),
        .clr (go),
        .en  (running),
        .incr(ftw_q),
        .acc (tx_acc)
    );

    dnco_phase_acc #(.W(PHASE_W)) u_lo_acc (
        .clk (clk),
        .rst (rst),
        .clr (go),
        .en  (running),
        .incr(ftw_q),
        .acc (lo_acc)
    );

    dnco_prn_chips #(.W(PRN_W), .TAP(PRN_TAP), .SEED(PRN_SEED)) u_prn (
        .clk      (clk),
        .rst      (rst),
        .restart  (go),
        .advance  (tick && coded),
        .delay    (active_q.delay),
        .tx_chip  (tx_chip),
        .lo_chip  (lo_chip),
        .last_chip(last_chip)
    );

    assign tx_phase   = tx_acc + ((coded && tx_chip) ? HALF_TURN : '0);
    assign lo_i_phase = lo_acc + ((coded && lo_chip) ? HALF_TURN : '0);
    assign lo_q_phase = lo_i_phase + QUARTER_TURN;

    dnco_sine_lut #(.AW(LUT_AW), .OUT_W(AMP_W)) u_tx_lut (
        .clk(clk),
        .rst(rst),
        .ph (tx_phase[PHASE_W-1 -: LUT_IN_W]),
        .amp(tx_amp)
    );

    dnco_sine_lut #(.AW(LUT_AW), .OUT_W(AMP_W)) u_loi_lut (
        .clk(clk),
        .rst(rst),
        .ph (lo_i_phase[PHASE_W-1 -: LUT_IN_W]),
        .amp(lo_i_amp)
    );

    dnco_sine_lut #(.AW(LUT_AW), .OUT_W(AMP_W)) u_loq_lut (
        .clk(clk),
        .rst(rst),
        .ph (lo_q_phase[PHASE_W-1 -: LUT_IN_W]),
        .amp(lo_q_amp)
    );

endmodule

// File: rtl/dnco_checker.sv
module dnco_checker
    import dnco_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_we,
    input logic [ADDR_W-1:0]       cfg_addr,
    input logic [PHASE_W-1:0]      tx_phase,
    input logic [PHASE_W-1:0]      lo_i_phase,
    input logic [PHASE_W-1:0]      lo_q_phase,
    input logic signed [AMP_W-1:0] tx_amp,
    input logic                    running
);

    logic go_seen;
    assign go_seen = cfg_we && (cfg_addr == 3'd6);

    // R1: go clears both accumulators on the same edge
    p_sync_clear_r1: assert property (@(posedge clk) disable iff (rst)
        go_seen |=> (((tx_phase & ~HALF_TURN) == '0) && ((lo_i_phase & ~HALF_TURN) == '0)));

    // R3: transmit and LO accumulators stay in lockstep
    p_lockstep_r3: assert property (@(posedge clk) disable iff (rst)
        ((tx_phase ^ lo_i_phase) & ~HALF_TURN) == '0);

    // R4: quadrature phase leads in-phase by a quarter turn
    p_quadrature_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_q_phase - lo_i_phase) == QUARTER_TURN);

    // R10: idle phases before the first go
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !running |-> ((tx_phase == '0) && (lo_i_phase == '0)));

    // R9: first half-turn gives a non-negative sample two clocks later
    p_amp_sign_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(tx_phase[PHASE_W-1], 2) |-> !tx_amp[AMP_W-1]);

    // R9: the most negative code never appears
    p_amp_floor_r9: assert property (@(posedge clk) disable iff (rst)
        tx_amp != {1'b1, {(AMP_W-1){1'b0}}});

endmodule

bind dual_nco_gen dnco_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .tx_phase  (tx_phase),
    .lo_i_phase(lo_i_phase),
    .lo_q_phase(lo_q_phase),
    .tx_amp    (tx_amp),
    .running   (running)
);

// File: tb/tb_dual_nco_gen.sv
module tb_dual_nco_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [47:0] cfg_wdata;
    logic [47:0] tx_phase;
    logic [47:0] lo_i_phase;
    logic [47:0] lo_q_phase;
    logic signed [13:0] tx_amp;
    logic signed [13:0] lo_i_amp;
    logic signed [13:0] lo_q_amp;

    localparam logic [9:0]  SEED  = 10'h001;
    localparam logic [47:0] HALF  = 48'h8000_0000_0000;
    localparam logic [47:0] QUART = 48'h4000_0000_0000;

    int n_vec = 0;
    int n_bad = 0;
    bit chips [1023];
    int ph_hist [1100];

    always #10 clk = ~clk;

    dual_nco_gen #(.PRN_SEED(SEED)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_phase(tx_phase), .lo_i_phase(lo_i_phase), .lo_q_phase(lo_q_phase),
        .tx_amp(tx_amp), .lo_i_amp(lo_i_amp), .lo_q_amp(lo_q_amp)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [47:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Program the holding set, then go; returns in the first cycle after go.
    task automatic setup(input logic [47:0] base, input logic [47:0] step, input int len,
                         input bit mode, input int delay, input int tick);
        wr(3'd0, base);
        wr(3'd1, step);
        wr(3'd2, 48'(len));
        wr(3'd3, 48'(mode));
        wr(3'd4, 48'(delay));
        wr(3'd5, 48'(tick));
        wr(3'd6, 48'd0);
    endtask

    function automatic int esin(int p);
        real v;
        v = 8191.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic logic [47:0] ramp_word(int c, int t, int l, logic [47:0] b, logic [47:0] s);
        return b + 48'((c / t) % l) * s;
    endfunction

    task automatic run_ramp(input logic [47:0] b0, input logic [47:0] b1, input logic [47:0] s,
                            input int l, input int t, input int ncyc, input int wr_at);
        logic [47:0] acc;
        logic [47:0] bb;
        acc = '0;
        for (int c = 0; c < ncyc; c++) begin
            chk(tx_phase == acc, (wr_at >= 0) ? "R8 ramp reload at sweep end" : "R5 ramp tuning word",
                64'(tx_phase), 64'(acc));
            chk(lo_i_phase == tx_phase, "R3 lo equals tx", 64'(lo_i_phase), 64'(tx_phase));
            chk(lo_q_phase == lo_i_phase + QUART, "R4 quadrature offset", 64'(lo_q_phase), 64'(lo_i_phase + QUART));
            bb = (wr_at >= 0 && c >= l * t) ? b1 : b0;
            acc = acc + ramp_word(c, t, l, bb, s);
            if (c == wr_at) begin
                cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = b1;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic run_coded(input int d, input int t, input logic [47:0] f, input int ncyc, input bit sw);
        logic [47:0] base;
        bit cd;
        bit txc;
        bit loc;
        int k;
        for (int c = 0; c < ncyc; c++) begin
            k    = c / t;
            base = 48'(c) * f;
            cd   = !(sw && c >= 1023 * t);
            txc  = chips[k % 1023];
            loc  = (k >= d) ? chips[(k - d) % 1023] : 1'b0;
            chk(tx_phase == base + ((cd && txc) ? HALF : 48'd0),
                cd ? "R6 tx chip offset" : "R8 mode change at code boundary",
                64'(tx_phase), 64'(base + ((cd && txc) ? HALF : 48'd0)));
            chk(lo_i_phase == base + ((cd && loc) ? HALF : 48'd0),
                cd ? "R7 lo delayed chip" : "R8 mode change at code boundary",
                64'(lo_i_phase), 64'(base + ((cd && loc) ? HALF : 48'd0)));
            if (sw && c == 100) begin
                cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 48'd0;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] s;
        s = SEED;
        for (int i = 0; i < 1023; i++) begin
            chips[i] = s[9];
            s = {s[8:0], s[9] ^ s[6]};
        end

        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_phase == '0, "R10 reset tx phase", 64'(tx_phase), 64'd0);
        chk(tx_amp == '0 && lo_i_amp == '0 && lo_q_amp == '0, "R9 reset amplitudes",
            64'(tx_amp), 64'd0);
        rst = 1'b0;

        // R10: writes without go leave the phases idle
        wr(3'd0, 48'h0000_1234_0000);
        repeat (5) @(negedge clk);
        chk(tx_phase == '0 && lo_i_phase == '0, "R10 idle before go", 64'(tx_phase), 64'd0);

        // R1/R2: constant tuning words, including wrap
        begin
            logic [47:0] fl [4];
            fl[0] = 48'h0000_0000_0001;
            fl[1] = 48'hFFFF_FFFF_FFF0;
            fl[2] = 48'h1234_5678_9ABC;
            fl[3] = 48'h0000_0300_0000_0;
            for (int j = 0; j < 4; j++) begin
                setup(fl[j], 48'd0, 1, 1'b0, 0, 1);
                chk(tx_phase == '0 && lo_i_phase == '0, "R1 cleared after go", 64'(tx_phase), 64'd0);
                for (int n = 1; n <= 20; n++) begin
                    @(negedge clk);
                    chk(tx_phase == 48'(n) * fl[j], "R2 phase advance", 64'(tx_phase), 64'(48'(n) * fl[j]));
                    chk(lo_q_phase == lo_i_phase + QUART, "R4 quadrature offset",
                        64'(lo_q_phase), 64'(lo_i_phase + QUART));
                end
            end
        end

        // R5: ramp with negative step, length 4, tick 3
        setup(48'h0100_0000_0000, -48'h0000_1000_0000, 4, 1'b0, 0, 3);
        run_ramp(48'h0100_0000_0000, 48'd0, -48'h0000_1000_0000, 4, 3, 40, -1);
        // R5: ramp with positive step, length 5, tick 1
        setup(48'h0000_0800_0000, 48'h0000_0004_0000, 5, 1'b0, 0, 1);
        run_ramp(48'h0000_0800_0000, 48'd0, 48'h0000_0004_0000, 5, 1, 23, -1);
        // R8: base rewritten mid-sweep applies only after the sweep end
        setup(48'h0100_0000_0000, 48'h0000_2000_0000, 4, 1'b0, 0, 3);
        run_ramp(48'h0100_0000_0000, 48'h0200_0000_0000, 48'h0000_2000_0000, 4, 3, 30, 2);

        // R6/R7: coded mode across several delays and the period boundary
        setup(48'd0, 48'd0, 1, 1'b1, 0, 1);
        run_coded(0, 1, 48'd0, 1100, 1'b0);
        setup(48'd0, 48'd0, 1, 1'b1, 1, 2);
        run_coded(1, 2, 48'd0, 2 * 1068, 1'b0);
        setup(48'd0, 48'd0, 1, 1'b1, 1022, 1);
        run_coded(1022, 1, 48'd0, 1023 + 45, 1'b0);
        setup(48'h0000_0300_0000_0007, 48'h1, 1, 1'b1, 3, 1);
        run_coded(3, 1, 48'h0000_0300_0000_0007, 40, 1'b0);
        // R8: mode switch queued mid-period takes hold at the 1023rd chip
        setup(48'd0, 48'd0, 1, 1'b1, 7, 2);
        run_coded(7, 2, 48'd0, 2 * 1023 + 60, 1'b1);

        // R9: full sweep of the 1024 table positions, two-clock latency
        setup(48'h0040_0000_0000, 48'd0, 1, 1'b0, 0, 1);
        for (int c = 0; c < 1030; c++) begin
            ph_hist[c] = int'(tx_phase[47:38]);
            if (c >= 2) begin
                int p;
                int a;
                p = ph_hist[c - 2];
                a = int'(tx_amp);
                chk(a - esin(p) <= 1 && esin(p) - a <= 1, "R9 tx amplitude", 64'(a), 64'(esin(p)));
                a = int'(lo_q_amp);
                chk(a - esin((p + 256) % 1024) <= 1 && esin((p + 256) % 1024) - a <= 1,
                    "R9 lo q amplitude", 64'(a), 64'(esin((p + 256) % 1024)));
                a = int'(lo_i_amp);
                chk(a != -8192, "R9 amplitude floor", 64'(a), 64'(esin(p)));
            end
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule